// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide parallel NOR-style flash device, together with a small parameterised storage array. A host issues bus writes by pulsing the write strobe while the chip select is low. The block turns one- and two-write sequences into device modes: array read, identifier read, program, program verify, single-step chip erase, erase verify, self-timed chip erase with status polling, and a software reset. Commands are honoured only while the programming-voltage flag is high. While the flag is low the part behaves as a read-only memory.

All strobes are sampled on the system clock. The address is captured when the write strobe is seen falling with the chip select low. The data byte is taken when the strobe is seen rising with the chip select still low, and that rising edge is the moment a command takes effect. Reads are combinational from the current mode, the address pins and the array, and appear on the shared data bus whenever chip select and output enable are low and the write strobe is high.

The self-timed erase first forces every byte to 00H, one byte per clock. It then waits `ERASE_CYCLES` clocks and finally sets every byte to FFH. While this runs, the status read drives only bit 7 of the data bus. That bit is low while busy and high when done.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte reads FFH and the block is in array-read mode, returning the byte at the address pins.
- R2: While `vpp_high` is low every write sequence is ignored and the mode is array read, so the block is in array read when the flag rises.
- R3: After a write of 90H, reads return 07H when address bit 0 is 0 and 19H when it is 1, whatever the other address bits are.
- R4: A write of 40H followed by a write of (PA, PD) makes byte PA equal to its old value AND PD, and returns to array read. After a write of C0H, reads return the byte at the last programmed address PA, whatever the address pins are.
- R5: A write of 20H followed by a second write of 20H sets every byte to FFH and returns to array read. A 20H followed by any other code erases nothing, and that other code is decoded as a new first write.
- R6: A write of 30H followed by 30H starts the self-timed erase. In status mode, data bit 7 is 0 for exactly 2^AW + ERASE_CYCLES clocks, then 1, and bits 6..0 are not driven. Afterwards every byte is FFH. All writes are ignored while it runs.
- R7: A write of A0H at address EA selects erase verify, in which reads return the byte at EA whatever the address pins are.
- R8: A write of FFH followed by FFH selects array read. Any first-write code other than 00H, 20H, 30H, 40H, 90H, A0H, C0H and FFH also selects array read.
- R9: The address of a write is the one present when the strobe falls with the chip select low; address changes while the strobe is low are ignored. A strobe rise while chip select is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vpp_high | input | 1 | Programming-voltage flag; commands are accepted only while high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| data | inout | 8 | Shared data bus: command or program byte in, read data out |

## Verification
A wrong mode register shows at once on the next read. An identifier code, a verify byte from the wrong address, or a status byte appears where array data is expected, within one clock of the write that caused it. A wrong program or erase result stays in the array and shows on the first later read of that byte. The reference model therefore compares the bus on every clock in which the block drives it. A busy count that is off by even one clock shows as a status bit 7 that rises one cycle early or late during polling.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    MD_READ, MD_IDENT, MD_PSETUP, MD_ESETUP, MD_ASETUP,
    MD_PVERIFY, MD_EVERIFY, MD_STATUS, MD_RSETUP
  } mode_e;

  localparam logic [DW-1:0] OP_READ  = 8'h00;
  localparam logic [DW-1:0] OP_IDENT = 8'h90;
  localparam logic [DW-1:0] OP_ERASE = 8'h20;
  localparam logic [DW-1:0] OP_AUTO  = 8'h30;
  localparam logic [DW-1:0] OP_PROG  = 8'h40;
  localparam logic [DW-1:0] OP_PVFY  = 8'hC0;
  localparam logic [DW-1:0] OP_EVFY  = 8'hA0;
  localparam logic [DW-1:0] OP_RESET = 8'hFF;
  localparam logic [DW-1:0] CODE_MFR = 8'h07;
  localparam logic [DW-1:0] CODE_DEV = 8'h19;

  // first-write decode; unknown codes fall back to array read
  function automatic mode_e first_cycle(input logic [DW-1:0] op);
    case (op)
      OP_IDENT: first_cycle = MD_IDENT;
      OP_ERASE: first_cycle = MD_ESETUP;
      OP_AUTO:  first_cycle = MD_ASETUP;
      OP_PROG:  first_cycle = MD_PSETUP;
      OP_PVFY:  first_cycle = MD_PVERIFY;
      OP_EVFY:  first_cycle = MD_EVERIFY;
      OP_RESET: first_cycle = MD_RSETUP;
      default:  first_cycle = MD_READ;
    endcase
  endfunction
endpackage

// File: rtl/flashcmd_strobe.sv
module flashcmd_strobe #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          evt,
  output logic [AW-1:0] evt_addr,
  output logic [DW-1:0] evt_data
);
  logic          we_q;
  logic [AW-1:0] addr_hold;
  logic          strobe_fall;

  assign strobe_fall = we_q & ~we_n & ~ce_n;
  assign evt         = ~we_q & we_n & ~ce_n;
  assign evt_addr    = addr_hold;
  assign evt_data    = din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      addr_hold <= '0;
    end else begin
      we_q <= we_n;
      if (strobe_fall) addr_hold <= addr;
    end
  end
endmodule

// File: rtl/flashcmd_fsm.sv
module flashcmd_fsm
  import flashcmd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_high,
  input  logic          evt,
  input  logic [AW-1:0] evt_addr,
  input  logic [DW-1:0] evt_data,
  input  logic          busy,
  output mode_e         mode,
  output logic          prog_en,
  output logic          erase_go,
  output logic          auto_go,
  output logic [AW-1:0] pv_addr,
  output logic [AW-1:0] ev_addr
);
  mode_e mode_nxt;
  logic  act;

  assign act = evt & vpp_high & ~busy;

  always_comb begin
    mode_nxt = mode;
    prog_en  = 1'b0;
    erase_go = 1'b0;
    auto_go  = 1'b0;
    if (act) begin
      case (mode)
        MD_PSETUP: begin
          prog_en  = 1'b1;
          mode_nxt = MD_READ;
        end
        MD_ESETUP: begin
          if (evt_data == OP_ERASE) begin
            erase_go = 1'b1;
            mode_nxt = MD_READ;
          end else mode_nxt = first_cycle(evt_data);
        end
        MD_ASETUP: begin
          if (evt_data == OP_AUTO) begin
            auto_go  = 1'b1;
            mode_nxt = MD_STATUS;
          end else mode_nxt = first_cycle(evt_data);
        end
        MD_RSETUP: begin
          if (evt_data == OP_RESET) mode_nxt = MD_READ;
          else mode_nxt = first_cycle(evt_data);
        end
        default: mode_nxt = first_cycle(evt_data);
      endcase
    end
    if (!vpp_high) mode_nxt = MD_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MD_READ;
      pv_addr <= '0;
      ev_addr <= '0;
    end else begin
      mode <= mode_nxt;
      if (prog_en) pv_addr <= evt_addr;
      if (act && mode_nxt == MD_EVERIFY) ev_addr <= evt_addr;
    end
  end
endmodule

// File: rtl/flashcmd_array.sv
module flashcmd_array
  import flashcmd_pkg::*;
#(
  parameter int AW           = 6,
  parameter int ERASE_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          erase_go,
  input  logic          auto_go,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(ERASE_CYCLES - 1);

  logic [DW-1:0] mem [DEPTH];
  logic          prewrite;
  logic [AW-1:0] idx;
  logic [CW-1:0] wcnt;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      busy     <= 1'b0;
      prewrite <= 1'b0;
      idx      <= '0;
      wcnt     <= '0;
    end else if (busy) begin
      if (prewrite) begin
        mem[idx] <= '0;
        idx      <= idx + 1'b1;
        if (idx == '1) begin
          prewrite <= 1'b0;
          wcnt     <= '0;
        end
      end else if (wcnt == WAIT_LAST) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        busy <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (auto_go) begin
      busy     <= 1'b1;
      prewrite <= 1'b1;
      idx      <= '0;
    end else if (erase_go) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog_en) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flashcmd_pkg::*;
#(
  parameter int AW           = 6,
  parameter int ERASE_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_high,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] data
);
  logic          evt;
  logic [AW-1:0] evt_addr;
  logic [DW-1:0] evt_data;
  logic [DW-1:0] data_in;
  mode_e         mode;
  logic          prog_en, erase_go, auto_go, busy;
  logic [AW-1:0] pv_addr, ev_addr, rd_addr;
  logic [DW-1:0] arr_data, rd_val;
  logic          read_on;
  logic [DW-1:0] oe_bits;

  assign data_in = data;

  flashcmd_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(data_in), .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  flashcmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .vpp_high(vpp_high), .evt(evt),
    .evt_addr(evt_addr), .evt_data(evt_data), .busy(busy), .mode(mode),
    .prog_en(prog_en), .erase_go(erase_go), .auto_go(auto_go),
    .pv_addr(pv_addr), .ev_addr(ev_addr)
  );

  flashcmd_array #(.AW(AW), .ERASE_CYCLES(ERASE_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(evt_addr),
    .prog_data(evt_data), .erase_go(erase_go), .auto_go(auto_go),
    .rd_addr(rd_addr), .rd_data(arr_data), .busy(busy)
  );

  always_comb begin
    case (mode)
      MD_PVERIFY: rd_addr = pv_addr;
      MD_EVERIFY: rd_addr = ev_addr;
      default:    rd_addr = addr;
    endcase
  end

  always_comb begin
    case (mode)
      MD_IDENT:  rd_val = addr[0] ? CODE_DEV : CODE_MFR;
      MD_STATUS: rd_val = {~busy, {(DW-1){1'b0}}};
      default:   rd_val = arr_data;
    endcase
  end

  assign read_on = ~ce_n & ~oe_n & we_n;

  for (genvar b = 0; b < DW; b++) begin : g_bus
    assign oe_bits[b] = read_on & ((mode != MD_STATUS) || (b == DW - 1));
    assign data[b]    = oe_bits[b] ? rd_val[b] : 1'bz;
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flashcmd_pkg::*;
#(
  parameter int AW           = 6,
  parameter int ERASE_CYCLES = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vpp_high,
  input mode_e         mode,
  input logic          busy,
  input logic          prog_en,
  input logic          erase_go,
  input logic          auto_go,
  input logic [DW-1:0] oe_bits
);
  localparam int RUN_LEN = (1 << AW) + ERASE_CYCLES;
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else bcnt <= 0;
  end

  // R2
  vpp_low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_high |=> mode == MD_READ);

  // R6
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_en || erase_go || auto_go));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> bcnt == RUN_LEN);

  // R6
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_go |=> busy && mode == MD_STATUS);

  // R6
  status_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MD_STATUS |-> oe_bits[DW-2:0] == '0);

  // R4
  prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> mode == MD_READ);

  // R5
  erase_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> mode == MD_READ && !busy);
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.AW(AW), .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vpp_high(vpp_high), .mode(mode), .busy(busy),
  .prog_en(prog_en), .erase_go(erase_go), .auto_go(auto_go), .oe_bits(oe_bits)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int AW = 6;
  localparam int EC = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vpp_high = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] tb_drv = '0;
  logic tb_en = 1'b0;
  wire  [7:0] dbus;

  assign dbus = tb_en ? tb_drv : 8'hzz;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .ERASE_CYCLES(EC)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .vpp_high(vpp_high), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .data(dbus)
  );

  // reference model: 0 read,1 ident,2 prog setup,3 erase setup,4 auto setup,
  // 5 prog verify,6 erase verify,7 status,8 reset setup
  logic [7:0] rmem [DEPTH];
  int rmode;
  int busy_cnt;
  bit prev_we;
  logic [AW-1:0] cap_a, pv_a, ev_a;

  function automatic int decode(input logic [7:0] op);
    case (op)
      8'h90: return 1;
      8'h20: return 3;
      8'h30: return 4;
      8'h40: return 2;
      8'hC0: return 5;
      8'hA0: return 6;
      8'hFF: return 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rmem[i] = 8'hFF;
      rmode = 0; busy_cnt = 0; prev_we = 1; cap_a = '0; pv_a = '0; ev_a = '0;
    end else begin
      bit fall, rise, was_busy;
      logic [7:0] d;
      fall = prev_we && !we_n && !ce_n;
      rise = !prev_we && we_n && !ce_n;
      was_busy = busy_cnt > 0;
      d = dbus;
      if (was_busy) begin
        if (busy_cnt > EC) rmem[DEPTH + EC - busy_cnt] = 8'h00;
        busy_cnt--;
        if (busy_cnt == 0) for (int i = 0; i < DEPTH; i++) rmem[i] = 8'hFF;
      end
      if (rise && vpp_high && !was_busy) begin
        case (rmode)
          2: begin rmem[cap_a] = rmem[cap_a] & d; pv_a = cap_a; rmode = 0; end
          3: if (d == 8'h20) begin
               for (int i = 0; i < DEPTH; i++) rmem[i] = 8'hFF; rmode = 0;
             end else rmode = decode(d);
          4: if (d == 8'h30) begin busy_cnt = DEPTH + EC; rmode = 7; end
             else rmode = decode(d);
          8: rmode = (d == 8'hFF) ? 0 : decode(d);
          default: rmode = decode(d);
        endcase
        if (rmode == 6) ev_a = cap_a;
      end
      if (!vpp_high) rmode = 0;
      if (fall) cap_a = addr;
      prev_we = we_n;
    end
  end

  // per-cycle comparison of the driven bus against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !ce_n && !oe_n && we_n) begin
      logic [7:0] e;
      case (rmode)
        1: e = addr[0] ? 8'h19 : 8'h07;
        5: e = rmem[pv_a];
        6: e = rmem[ev_a];
        7: e = {busy_cnt == 0, 7'h00};
        default: e = rmem[addr];
      endcase
      n_checks++;
      if (rmode == 7) begin
        if (dbus[7] !== e[7]) begin
          n_fail++;
          $display("FAIL R6 cycle status bit7 actual %b expected %b", dbus[7], e[7]);
        end
      end else if (dbus !== e) begin
        n_fail++;
        $display("FAIL R1 cycle compare mode %0d actual %02h expected %02h", rmode, dbus, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 1; addr = a; tb_drv = d; tb_en = 1; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; tb_en = 0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk); #3;
    n_checks++;
    if (dbus !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, dbus, exp);
    end
    oe_n = 1; ce_n = 1;
  endtask

  task automatic rd7(input string tag, input logic exp);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); #3;
    n_checks++;
    if (dbus[7] !== exp) begin
      n_fail++;
      $display("FAIL %s status bit7 actual %b expected %b", tag, dbus[7], exp);
    end
    oe_n = 1; ce_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 0, 8'hFF);
    rd("R1", 63, 8'hFF);
    // R2 flag low: program attempt ignored
    wr(5, 8'h40); wr(5, 8'h00);
    rd("R2", 5, 8'hFF);
    @(negedge clk); vpp_high = 1;
    rd("R2", 5, 8'hFF);
    // R4 program ANDs, verify uses program address
    wr(5, 8'h40); wr(5, 8'h5A);
    rd("R4", 5, 8'h5A);
    wr(5, 8'h40); wr(5, 8'hF0);
    rd("R4", 5, 8'h50);
    wr(0, 8'hC0);
    rd("R4", 9, 8'h50);
    // R3 identifier
    wr(0, 8'h90);
    rd("R3", 0, 8'h07);
    rd("R3", 1, 8'h19);
    rd("R3", 62, 8'h07);
    // R8 unknown code back to read
    wr(0, 8'h55);
    rd("R8", 5, 8'h50);
    // R7 erase verify at given address
    wr(5, 8'hA0);
    rd("R7", 0, 8'h50);
    // R5 single 20H then program: no erase
    wr(10, 8'h40); wr(10, 8'h0F);
    wr(0, 8'h20); wr(0, 8'h40); wr(11, 8'h33);
    rd("R5", 10, 8'h0F);
    rd("R5", 11, 8'h33);
    wr(0, 8'h20); wr(0, 8'h20);
    rd("R5", 10, 8'hFF);
    rd("R5", 5, 8'hFF);
    // R8 reset sequence
    wr(0, 8'h90); wr(0, 8'hFF); wr(0, 8'hFF);
    rd("R8", 1, 8'hFF);
    wr(0, 8'hFF); wr(0, 8'h90);
    rd("R8", 1, 8'h19);
    wr(0, 8'h00);
    // R9 rise with CE high ignored
    @(negedge clk); ce_n = 1; addr = 0; tb_drv = 8'h90; tb_en = 1; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); tb_en = 0;
    rd("R9", 1, 8'hFF);
    // R9 address from falling edge
    wr(0, 8'h40);
    @(negedge clk); ce_n = 0; addr = 20; tb_drv = 8'h3C; tb_en = 1; we_n = 0;
    @(negedge clk); addr = 21;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; tb_en = 0;
    rd("R9", 20, 8'h3C);
    rd("R9", 21, 8'hFF);
    // R6 self-timed erase
    wr(3, 8'h40); wr(3, 8'h12);
    wr(0, 8'h30); wr(0, 8'h30);
    rd7("R6", 1'b0);
    wr(0, 8'hFF); wr(0, 8'hFF);
    rd7("R6", 1'b0);
    repeat (120) @(negedge clk);
    rd7("R6", 1'b1);
    wr(0, 8'h00);
    rd("R6", 3, 8'hFF);
    rd("R6", 20, 8'hFF);
    done = 1;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule